// File: doc/BRIEF.md
# Memory-to-Memory Move Sequencer

This block carries out one instruction that copies a single word from one RAM location to another without routing it through a general register. The instruction argument names two general registers. One holds the source address and the other holds the destination address. A flag in the argument chooses between plain absolute addressing and addressing relative to the current offset. The offset is added only when the flag is set and the offset unit reports that an offset is active.

An accepted instruction runs through a fixed four-step sequence. The block reads both address registers through two register-file read ports and presents the source address to a single-port synchronous RAM. It waits one cycle for the RAM to return the word, then writes that word to the destination address. A one-cycle done pulse closes the sequence. The block raises `busy` for the whole run and accepts a new instruction only while idle.

Top module: `memMoveSeq`

## Requirements
- R1: The argument `instArg` is decoded as follows. Bit 23 is the addressing flag, bits 22:19 are the source-register index and bits 18:15 are the destination-register index. Bits 14:0 have no effect on any output or on memory.
- R2: With flag 0, both effective addresses are the low `ADDR_W` bits of the named registers. This holds whether or not an offset is active.
- R3: With flag 1 and `offsetOn` high, each effective address is the register value plus `offsetVal`, both taken to their low `ADDR_W` bits, and the sum wraps modulo 2^`ADDR_W`. The same rule applies to source and destination.
- R4: With flag 1 and `offsetOn` low, both effective addresses fall back to the absolute form of R2.
- R5: An instruction is accepted at a clock edge where `instValid` and `instReady` are both high. In the next cycle `ramRdEn` is high with the source address. Two cycles later `ramWrEn` is high with the destination address. In the cycle after that, `done` is high for exactly one cycle. Read, write and done never overlap.
- R6: After the sequence, the destination location holds the word that the source location held before it. When source and destination are the same address, the write still occurs and the contents are unchanged.
- R7: `instReady` is high only while idle. `instValid` and `instArg` are ignored while a move is in progress.
- R8: `busy` is high from the cycle after acceptance through the done cycle, and low otherwise. After reset, `busy` and `done` are low, `instReady` is high, and neither RAM strobe is asserted.
- R9: `ramWdata` in the write cycle equals the word the RAM returned in the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present |
| instReady | output | 1 | Block idle and able to accept |
| instArg | input | ARG_W (24) | Instruction argument: flag, source index, destination index |
| offsetVal | input | OFS_W (24) | Current offset value |
| offsetOn | input | 1 | Offset currently active |
| rfSrcIdx | output | IDX_W (4) | Register-file read index for the source address |
| rfSrcData | input | REG_W (32) | Register contents at `rfSrcIdx` (combinational read) |
| rfDstIdx | output | IDX_W (4) | Register-file read index for the destination address |
| rfDstData | input | REG_W (32) | Register contents at `rfDstIdx` (combinational read) |
| ramAddr | output | ADDR_W (8) | RAM address |
| ramRdEn | output | 1 | RAM read strobe |
| ramWrEn | output | 1 | RAM write strobe |
| ramWdata | output | DATA_W (32) | RAM write data |
| ramRdata | input | DATA_W (32) | RAM read data, valid the cycle after a read |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The move is tried with flag 0 while an offset is active, which shows that absolute addressing ignores the offset. It is tried with flag 1 both with the offset on and with it off, which separates offset-relative addressing from the fallback. A register value with high bits set and an offset whose sum wraps past the top of the address space exposes truncation and wrap errors. An argument with all ignored bits set, and a move whose source and destination coincide, test the decode boundaries and the self-copy case. A run where `instValid` stays high with a changed argument while busy shows whether the captured argument is protected, because a second destination must stay untouched.

// File: rtl/memMovePkg.sv
package memMovePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } mvState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadArg;   // capture the instruction argument
    logic loadDst;   // capture the destination address
    logic loadData;  // capture the RAM read word
    logic rdEn;      // present source address, read
    logic wrEn;      // present destination address, write
  } mvStrobe_t;

endpackage

// File: rtl/memMoveAddrGen.sv
module memMoveAddrGen #(
  parameter int REG_W  = 32,
  parameter int OFS_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic [REG_W-1:0]  regVal,
  input  logic [OFS_W-1:0]  offsetVal,
  input  logic              addOfs,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] ofsPart;
  logic unusedHigh;

  assign ofsPart    = addOfs ? offsetVal[ADDR_W-1:0] : '0;
  assign addr       = regVal[ADDR_W-1:0] + ofsPart;  // wraps modulo 2^ADDR_W
  assign unusedHigh = ^{regVal, offsetVal};

endmodule

// File: rtl/memMoveCtrl.sv
module memMoveCtrl
  import memMovePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  output logic       instReady,
  output logic       busy,
  output logic       done,
  output mvStrobe_t  strobe
);

  mvState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        strobe.loadArg = instValid;
        if (instValid) stateNext = ST_READ;
      end
      ST_READ: begin
        strobe.rdEn    = 1'b1;
        strobe.loadDst = 1'b1;
        stateNext      = ST_WAIT;
      end
      ST_WAIT: begin
        strobe.loadData = 1'b1;
        stateNext       = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.wrEn = 1'b1;
        stateNext   = ST_DONE;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign instReady = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);

  // R5: acceptance is followed by the read
  assert_accept_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> strobe.rdEn);

  // R5: the write comes two cycles after the read
  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> $past(strobe.rdEn, 2));

  // R5: read, write and done are mutually exclusive
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdEn, strobe.wrEn, done}));

  // R8: busy starts after acceptance and blocks new instructions
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> (busy && !instReady));

  // R8: done releases the block
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && instReady));

endmodule

// File: rtl/memMoveDatapath.sv
module memMoveDatapath
  import memMovePkg::*;
#(
  parameter int ARG_W  = 24,
  parameter int IDX_W  = 4,
  parameter int REG_W  = 32,
  parameter int OFS_W  = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mvStrobe_t         strobe,
  input  logic [ARG_W-1:0]  instArg,
  input  logic [OFS_W-1:0]  offsetVal,
  input  logic              offsetOn,
  output logic [IDX_W-1:0]  rfSrcIdx,
  input  logic [REG_W-1:0]  rfSrcData,
  output logic [IDX_W-1:0]  rfDstIdx,
  input  logic [REG_W-1:0]  rfDstData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata
);

  localparam int FLAG_POS = ARG_W - 1;
  localparam int SRC_LSB  = FLAG_POS - IDX_W;
  localparam int DST_LSB  = SRC_LSB - IDX_W;

  logic              flagQ;
  logic [IDX_W-1:0]  srcIdxQ, dstIdxQ;
  logic [ADDR_W-1:0] dstAddrQ;
  logic [DATA_W-1:0] dataQ;
  logic              useOfs;
  logic unusedArgBits;

  logic [REG_W-1:0]  regVals [2];
  logic [ADDR_W-1:0] effAddr [2];

  assign unusedArgBits = ^instArg[DST_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      srcIdxQ  <= '0;
      dstIdxQ  <= '0;
      dstAddrQ <= '0;
      dataQ    <= '0;
    end else begin
      if (strobe.loadArg) begin
        flagQ   <= instArg[FLAG_POS];
        srcIdxQ <= instArg[SRC_LSB +: IDX_W];
        dstIdxQ <= instArg[DST_LSB +: IDX_W];
      end
      if (strobe.loadDst)  dstAddrQ <= effAddr[1];
      if (strobe.loadData) dataQ    <= ramRdata;
    end
  end

  assign rfSrcIdx   = srcIdxQ;
  assign rfDstIdx   = dstIdxQ;
  assign useOfs     = flagQ & offsetOn;
  assign regVals[0] = rfSrcData;
  assign regVals[1] = rfDstData;

  // One address generator each for source (0) and destination (1)
  for (genvar g = 0; g < 2; g++) begin : genAddr
    memMoveAddrGen #(
      .REG_W (REG_W),
      .OFS_W (OFS_W),
      .ADDR_W(ADDR_W)
    ) uAddrGen (
      .regVal   (regVals[g]),
      .offsetVal(offsetVal),
      .addOfs   (useOfs),
      .addr     (effAddr[g])
    );
  end

  assign ramRdEn  = strobe.rdEn;
  assign ramWrEn  = strobe.wrEn;
  assign ramAddr  = strobe.rdEn ? effAddr[0] : (strobe.wrEn ? dstAddrQ : '0);
  assign ramWdata = strobe.wrEn ? dataQ : '0;

  // R9: the written word is the word returned after the read
  assert_wdata_R9: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (ramWdata == $past(ramRdata)));

  // R2: absolute source address when the flag is clear
  assert_abs_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ramRdEn && !flagQ) |-> (ramAddr == rfSrcData[ADDR_W-1:0]));

  // R4: no offset while the offset unit reports it inactive
  assert_no_ofs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ramRdEn && !offsetOn) |-> (ramAddr == rfSrcData[ADDR_W-1:0]));

endmodule

// File: rtl/memMoveSeq.sv
module memMoveSeq
  import memMovePkg::*;
#(
  parameter int ARG_W  = 24,
  parameter int IDX_W  = 4,
  parameter int REG_W  = 32,
  parameter int OFS_W  = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [ARG_W-1:0]  instArg,
  input  logic [OFS_W-1:0]  offsetVal,
  input  logic              offsetOn,
  output logic [IDX_W-1:0]  rfSrcIdx,
  input  logic [REG_W-1:0]  rfSrcData,
  output logic [IDX_W-1:0]  rfDstIdx,
  input  logic [REG_W-1:0]  rfDstData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              busy,
  output logic              done
);

  mvStrobe_t strobe;

  memMoveCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instReady(instReady),
    .busy     (busy),
    .done     (done),
    .strobe   (strobe)
  );

  memMoveDatapath #(
    .ARG_W (ARG_W),
    .IDX_W (IDX_W),
    .REG_W (REG_W),
    .OFS_W (OFS_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .instArg  (instArg),
    .offsetVal(offsetVal),
    .offsetOn (offsetOn),
    .rfSrcIdx (rfSrcIdx),
    .rfSrcData(rfSrcData),
    .rfDstIdx (rfDstIdx),
    .rfDstData(rfDstData),
    .ramAddr  (ramAddr),
    .ramRdEn  (ramRdEn),
    .ramWrEn  (ramWrEn),
    .ramWdata (ramWdata),
    .ramRdata (ramRdata)
  );

endmodule

// File: tb/memMoveSeq_test.sv
module memMoveSeq_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  logic        rstN, instValid, instReady, offsetOn;
  logic [23:0] instArg, offsetVal;
  logic [3:0]  rfSrcIdx, rfDstIdx;
  logic [31:0] rfSrcData, rfDstData;
  logic [7:0]  ramAddr;
  logic        ramRdEn, ramWrEn, busy, done;
  logic [31:0] ramWdata, ramRdata;

  logic [31:0] rf [16];
  logic [31:0] mem [256];
  logic [31:0] refMem [256];

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string curReq = "R2";

  memMoveSeq uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instArg(instArg), .offsetVal(offsetVal), .offsetOn(offsetOn),
    .rfSrcIdx(rfSrcIdx), .rfSrcData(rfSrcData),
    .rfDstIdx(rfDstIdx), .rfDstData(rfDstData),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn),
    .ramWdata(ramWdata), .ramRdata(ramRdata), .busy(busy), .done(done)
  );

  assign rfSrcData = rf[rfSrcIdx];
  assign rfDstData = rf[rfDstIdx];

  // Synchronous single-port RAM, one cycle of read latency
  always @(posedge clk) begin
    if (ramRdEn) ramRdata <= mem[ramAddr];
    if (ramWrEn) mem[ramAddr] <= ramWdata;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] effA(logic f, logic [31:0] r);
    return (f && offsetOn) ? r[7:0] + offsetVal[7:0] : r[7:0];
  endfunction

  // Behavioural reference: phase 0 idle, 1 read, 2 wait, 3 write, 4 done
  int         phase;
  logic [7:0] mSrc, mDst;

  always @(posedge clk) begin
    if (!rstN) phase <= 0;
    else begin
      case (phase)
        0: if (instValid) begin
             phase <= 1;
             mSrc  <= effA(instArg[23], rf[instArg[22:19]]);
             mDst  <= effA(instArg[23], rf[instArg[18:15]]);
           end
        3: begin refMem[mDst] <= refMem[mSrc]; phase <= 4; end
        4: phase <= 0;
        default: phase <= phase + 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R8", "busy", {31'b0, busy}, {31'b0, phase != 0});
      chk("R7", "instReady", {31'b0, instReady}, {31'b0, phase == 0});
      chk("R5", "ramRdEn", {31'b0, ramRdEn}, {31'b0, phase == 1});
      chk("R5", "ramWrEn", {31'b0, ramWrEn}, {31'b0, phase == 3});
      chk("R5", "done", {31'b0, done}, {31'b0, phase == 4});
      if (phase == 1) chk(curReq, "source address", {24'b0, ramAddr}, {24'b0, mSrc});
      if (phase == 3) begin
        chk(curReq, "destination address", {24'b0, ramAddr}, {24'b0, mDst});
        chk("R9", "write data", ramWdata, refMem[mSrc]);
      end
    end
  end

  // One move: checks the destination word at the ports of the RAM afterwards
  task automatic doMove(logic f, logic [3:0] s, logic [3:0] d, logic [14:0] low, string req);
    logic [7:0]  sa, da;
    logic [31:0] expVal;
    sa = effA(f, rf[s]);
    da = effA(f, rf[d]);
    expVal = mem[sa];
    @(negedge clk);
    curReq    = req;
    instValid = 1'b1;
    instArg   = {f, s, d, low};
    @(negedge clk);
    instValid = 1'b0;
    repeat (5) @(negedge clk);
    chk(req, "destination word", mem[da], expVal);
    chk("R6", "source word kept", mem[sa], expVal);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 32'hA500_0000 + i * 7;
      refMem[i] = 32'hA500_0000 + i * 7;
    end
    for (int i = 0; i < 16; i++) rf[i] = 32'(i * 3);
    rf[1] = 4; rf[2] = 20; rf[3] = 32'h1234_0107; rf[4] = 250;
    rf[5] = 60; rf[0] = 100; rf[15] = 9; rf[6] = 200;
    rstN = 1'b0; instValid = 1'b0; instArg = '0;
    offsetVal = 24'd5; offsetOn = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state (R8)
    chk("R8", "reset busy", {31'b0, busy}, 32'd0);
    chk("R8", "reset done", {31'b0, done}, 32'd0);
    chk("R8", "reset ready", {31'b0, instReady}, 32'd1);
    chk("R8", "reset strobes", {30'b0, ramRdEn, ramWrEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    doMove(1'b0, 4'd1, 4'd2, 15'd0, "R2");         // 4 -> 20, offset ignored
    doMove(1'b1, 4'd1, 4'd5, 15'd0, "R3");         // 9 -> 65
    offsetOn = 1'b0;
    doMove(1'b1, 4'd2, 4'd1, 15'd0, "R4");         // 20 -> 4
    offsetOn = 1'b1;
    offsetVal = 24'h01010A;
    doMove(1'b1, 4'd4, 4'd5, 15'd0, "R3");         // 250+10 wraps to 4 -> 70
    doMove(1'b0, 4'd3, 4'd0, 15'h7FFF, "R1");      // 0x07 -> 100, ignored bits set
    doMove(1'b0, 4'd3, 4'd0, 15'h0000, "R1");      // same again, ignored bits clear
    doMove(1'b1, 4'd15, 4'd15, 15'd0, "R6");       // 19 -> 19 self copy

    // R7: valid held high with a new argument while busy
    offsetOn = 1'b0;
    @(negedge clk);
    curReq = "R7";
    instValid = 1'b1;
    instArg = {1'b0, 4'd2, 4'd0, 15'd0};           // 20 -> 100
    @(negedge clk);
    instArg = {1'b0, 4'd1, 4'd6, 15'd0};           // would be 4 -> 200
    repeat (3) @(negedge clk);
    instValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "accepted move", mem[100], mem[20]);
    chk("R7", "ignored destination", mem[200], 32'hA500_0000 + 200 * 7);

    for (int i = 0; i < 256; i++)
      if (mem[i] !== refMem[i]) chk("R6", "memory image", mem[i], refMem[i]);
    checks++;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule